// File: doc/BRIEF.md
# Banked Strided Vector Load Unit

This block runs one vector load at a time. A caller hands it a starting word address, a word stride and an element count. The unit works out the address of every element and sends one request per cycle to an array of interleaved, single-ported memory banks. Each element comes back on an output stream, in element order and tagged with its index. A one-cycle completion flag marks the end of the load.

Each bank stays busy for a fixed time after it is accessed. The unit keeps a separate down-counter for every bank. Before it issues an element, it looks at the counter of that element's bank in the same cycle. If the bank is still busy, issue holds until the bank is free. The stride alone therefore decides how a load behaves:

- When consecutive accesses spread over enough banks, the load streams at one element per cycle.
- When the stride keeps returning to the same bank, the load serialises on that bank's busy time.

Top module: `strided_vload_unit`

## Requirements
- R1: Element k is read from word address base + k*stride, taken modulo 2^32, so a stride of all ones walks downward. The request's bank field is the low 3 bits of that word address (address modulo 8 banks). The row field is the remaining upper 29 bits.
- R2: After a request to a bank, no further request goes to the same bank for the next 5 cycles. The earliest next request to that bank is 6 cycles after the previous one.
- R3: Requests go out strictly in element order. Element k is requested in the first cycle that is both after element k-1's request and at least 6 cycles after the last request to its bank. Element 0 is requested in the cycle right after the start is accepted.
- R4: Element k appears on the output exactly 12 cycles after its request cycle. Its data is the word the bank returned for it.
- R5: A 64-element load with stride 1 delivers its last element in the 76th cycle after start acceptance (relative cycle 75).
- R6: A 64-element load with stride 32 hits one bank on every access. It delivers its last element in relative cycle 390, so it takes 391 cycles.
- R7: Elements are delivered exactly once each, with the valid flag, indices 0, 1, 2 ... in order, and no element outside the requested length.
- R8: After reset, busy, done, request valid and element valid are all low. Busy is high from the cycle after start acceptance until done. Done is a single-cycle pulse in the cycle after the last element. Busy is low during that done cycle.
- R9: A start pulse that arrives while a load is in progress is ignored. The running load's addresses, timing and element count are unchanged, and no second done occurs.
- R10: A length from 1 to 64 is accepted. A start with length 0 or above 64 is ignored: busy stays low and no bank request is made.
- R11: The same bank comes back every LCM(stride, 8)/stride accesses. A stride of 3 (revisit after 8) streams at one element per cycle. A stride of 2 (revisit after 4) stalls, taking 6 cycles for every group of 4 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| base_i | input | 32 | Word address of element 0 |
| stride_i | input | 32 | Word stride between elements (modulo 2^32) |
| len_i | input | 7 | Number of elements, 1 to 64 |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse after the last element |
| req_valid_o | output | 1 | Bank request issued this cycle |
| req_bank_o | output | 3 | Target bank of the request |
| req_row_o | output | 29 | Word row inside the target bank |
| rsp_valid_i | input | 1 | Bank read data valid, one cycle after the request |
| rsp_data_i | input | 64 | Bank read data |
| elem_valid_o | output | 1 | Element output valid |
| elem_idx_o | output | 6 | Index of the delivered element |
| elem_data_o | output | 64 | Data of the delivered element |

## Verification
Some rules hold on every cycle, and the bound checker watches them continuously:

- No bank is requested again within its rest window.
- Delivered indices always rise by one.
- Done is a lone pulse that follows an element.
- Busy only falls together with done.
- No request appears while idle.

Other properties need the bench's directed loads, each compared with a cycle model built from the bank-busy rule:

- The exact issue cycles and the 12-cycle latency.
- The stride-dependent totals: 76 and 391 cycles, the stalled stride-2 pattern and the streaming stride-3 pattern.
- Address wrap-around and the data values.
- Rejection of starts that are illegal or arrive while busy.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

   typedef enum logic [1:0] {
      VL_IDLE  = 2'd0,
      VL_ISSUE = 2'd1,
      VL_DRAIN = 2'd2
   } vl_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/vlu_addr_gen.sv
module vlu_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int BANK_W = 3,
   parameter int LEN_W  = 7,
   parameter int IDX_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic [ADDR_W-1:0]        base_i,
   input  logic [ADDR_W-1:0]        stride_i,
   input  logic [LEN_W-1:0]         len_i,
   input  logic                     advance_i,
   output logic                     pending_o,
   output logic [BANK_W-1:0]        bank_o,
   output logic [ADDR_W-BANK_W-1:0] row_o,
   output logic [IDX_W-1:0]         idx_o,
   output logic [IDX_W-1:0]         last_idx_o
);

   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] stride_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  len_m1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         stride_q <= '0;
         cnt_q    <= '0;
         len_q    <= '0;
      end else if (load_i) begin
         addr_q   <= base_i;
         stride_q <= stride_i;
         cnt_q    <= '0;
         len_q    <= len_i;
      end else if (advance_i) begin
         addr_q   <= addr_q + stride_q;
         cnt_q    <= cnt_q + LEN_W'(1);
      end
   end

   assign len_m1     = len_q - LEN_W'(1);
   assign pending_o  = (cnt_q != len_q);
   assign bank_o     = addr_q[BANK_W-1:0];
   assign row_o      = addr_q[ADDR_W-1:BANK_W];
   assign idx_o      = cnt_q[IDX_W-1:0];
   assign last_idx_o = len_m1[IDX_W-1:0];

endmodule

// File: rtl/vlu_bank_timer.sv
module vlu_bank_timer #(
   parameter int NUM_BANKS = 8,
   parameter int BANK_W    = 3,
   parameter int BANK_BUSY = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hit_i,
   input  logic [BANK_W-1:0]    hit_bank_i,
   output logic [NUM_BANKS-1:0] free_o
);

   localparam int CNT_W = $clog2(BANK_BUSY);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BANK_BUSY - 1);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [CNT_W-1:0] rest_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rest_q <= '0;
         end else if (hit_i && (hit_bank_i == BANK_W'(b))) begin
            rest_q <= RELOAD;
         end else if (rest_q != '0) begin
            rest_q <= rest_q - CNT_W'(1);
         end
      end

      assign free_o[b] = (rest_q == '0);
   end

endmodule

// File: rtl/vlu_resp_pipe.sv
module vlu_resp_pipe #(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 6,
   parameter int STAGES = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic [IDX_W-1:0]  in_idx_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic [IDX_W-1:0]  out_idx_o
);

   logic              v_q [STAGES];
   logic [DATA_W-1:0] d_q [STAGES];
   logic [IDX_W-1:0]  x_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic              v_in;
      logic [DATA_W-1:0] d_in;
      logic [IDX_W-1:0]  x_in;

      if (s == 0) begin : g_head
         assign v_in = in_valid_i;
         assign d_in = in_data_i;
         assign x_in = in_idx_i;
      end else begin : g_body
         assign v_in = v_q[s-1];
         assign d_in = d_q[s-1];
         assign x_in = x_q[s-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) v_q[s] <= 1'b0;
         else        v_q[s] <= v_in;
      end

      always_ff @(posedge clk) begin
         d_q[s] <= d_in;
         x_q[s] <= x_in;
      end
   end

   assign out_valid_o = v_q[STAGES-1];
   assign out_data_o  = d_q[STAGES-1];
   assign out_idx_o   = x_q[STAGES-1];

endmodule

// File: rtl/strided_vload_unit.sv
module strided_vload_unit #(
   parameter  int ADDR_W    = 32,
   parameter  int DATA_W    = 64,
   parameter  int NUM_BANKS = 8,
   parameter  int BANK_BUSY = 6,
   parameter  int LOAD_LAT  = 12,
   parameter  int MAX_LEN   = 64,
   localparam int BANK_W    = $clog2(NUM_BANKS),
   localparam int ROW_W     = ADDR_W - BANK_W,
   localparam int LEN_W     = $clog2(MAX_LEN + 1),
   localparam int IDX_W     = $clog2(MAX_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] stride_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              req_valid_o,
   output logic [BANK_W-1:0] req_bank_o,
   output logic [ROW_W-1:0]  req_row_o,
   input  logic              rsp_valid_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   output logic              elem_valid_o,
   output logic [IDX_W-1:0]  elem_idx_o,
   output logic [DATA_W-1:0] elem_data_o
);
   import vlu_pkg::*;

   // The bank read itself takes one cycle; the delay line supplies the rest.
   localparam int PIPE_STAGES = LOAD_LAT - 1;

   if (!is_pow2(NUM_BANKS) || NUM_BANKS < 2) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (BANK_BUSY < 2) begin : g_bad_busy
      $error("BANK_BUSY must be at least 2");
   end
   if (LOAD_LAT < 2) begin : g_bad_lat
      $error("LOAD_LAT must be at least 2");
   end
   if (MAX_LEN < 2 || ADDR_W <= BANK_W) begin : g_bad_len
      $error("MAX_LEN or ADDR_W out of range");
   end

   vl_state_e              state_q;
   logic                   accept;
   logic                   len_ok;
   logic                   pending;
   logic                   fire;
   logic [NUM_BANKS-1:0]   bank_free;
   logic [IDX_W-1:0]       cur_idx;
   logic [IDX_W-1:0]       last_idx;
   logic [IDX_W-1:0]       tag_q;
   logic                   last_out;
   logic                   done_q;

   assign len_ok = (len_i != '0) && (len_i <= LEN_W'(MAX_LEN));
   assign accept = (state_q == VL_IDLE) && start_i && len_ok;

   vlu_addr_gen #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .LEN_W  (LEN_W),
      .IDX_W  (IDX_W)
   ) u_agen (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .base_i     (base_i),
      .stride_i   (stride_i),
      .len_i      (len_i),
      .advance_i  (fire),
      .pending_o  (pending),
      .bank_o     (req_bank_o),
      .row_o      (req_row_o),
      .idx_o      (cur_idx),
      .last_idx_o (last_idx)
   );

   vlu_bank_timer #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .BANK_BUSY (BANK_BUSY)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (fire),
      .hit_bank_i (req_bank_o),
      .free_o     (bank_free)
   );

   // Issue looks at the target bank's counter in the issuing cycle.
   assign fire        = pending && bank_free[req_bank_o];
   assign req_valid_o = fire;

   always_ff @(posedge clk) begin
      if (!rst_n)    tag_q <= '0;
      else if (fire) tag_q <= cur_idx;
   end

   vlu_resp_pipe #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .STAGES (PIPE_STAGES)
   ) u_pipe (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (rsp_valid_i),
      .in_data_i   (rsp_data_i),
      .in_idx_i    (tag_q),
      .out_valid_o (elem_valid_o),
      .out_data_o  (elem_data_o),
      .out_idx_o   (elem_idx_o)
   );

   assign last_out = elem_valid_o && (elem_idx_o == last_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= VL_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= (state_q == VL_DRAIN) && last_out;
         case (state_q)
            VL_IDLE:  if (accept)   state_q <= VL_ISSUE;
            VL_ISSUE: if (!pending) state_q <= VL_DRAIN;
            VL_DRAIN: if (last_out) state_q <= VL_IDLE;
            default:                state_q <= VL_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != VL_IDLE);
   assign done_o = done_q;

endmodule

// File: rtl/vlu_checker.sv
module vlu_checker #(
   parameter int NUM_BANKS = 8,
   parameter int BANK_W    = 3,
   parameter int BANK_BUSY = 6,
   parameter int IDX_W     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              req_valid_o,
   input logic [BANK_W-1:0] req_bank_o,
   input logic              elem_valid_o,
   input logic [IDX_W-1:0]  elem_idx_o
);

   localparam int GAP_W = $clog2(BANK_BUSY + 1);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
      logic [GAP_W-1:0] since_q;
      logic             hit;

      assign hit = req_valid_o && (req_bank_o == BANK_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n)                         since_q <= GAP_W'(BANK_BUSY);
         else if (hit)                       since_q <= GAP_W'(1);
         else if (since_q < GAP_W'(BANK_BUSY)) since_q <= since_q + GAP_W'(1);
      end

      // R2: a bank rests for its full busy time between requests
      p_bank_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> (since_q >= GAP_W'(BANK_BUSY)));
   end

   logic [IDX_W-1:0] prev_idx_q;
   always_ff @(posedge clk) begin
      if (!rst_n)            prev_idx_q <= '0;
      else if (elem_valid_o) prev_idx_q <= elem_idx_o;
   end

   p_in_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_valid_o && (elem_idx_o != '0)) |-> (elem_idx_o == prev_idx_q + IDX_W'(1)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_after_elem_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(elem_valid_o));

   p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   p_idle_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !req_valid_o);

endmodule

bind strided_vload_unit vlu_checker #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W),
   .BANK_BUSY (BANK_BUSY),
   .IDX_W     (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .req_valid_o  (req_valid_o),
   .req_bank_o   (req_bank_o),
   .elem_valid_o (elem_valid_o),
   .elem_idx_o   (elem_idx_o)
);

// File: tb/sim_strided_vload_unit.sv
`timescale 1ns/1ps
module sim_strided_vload_unit;

   localparam int AW = 32, DW = 64, NB = 8, BUSY = 6, LAT = 12, MAXL = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [31:0]   base = '0, stride = '0;
   logic [6:0]    len = '0;
   logic          busy, done, req_valid, rsp_valid, elem_valid;
   logic [2:0]    req_bank;
   logic [28:0]   req_row;
   logic [63:0]   rsp_data, elem_data;
   logic [5:0]    elem_idx;

   always #4 clk = ~clk;

   strided_vload_unit u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base),
      .stride_i(stride), .len_i(len), .busy_o(busy), .done_o(done),
      .req_valid_o(req_valid), .req_bank_o(req_bank), .req_row_o(req_row),
      .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
      .elem_valid_o(elem_valid), .elem_idx_o(elem_idx), .elem_data_o(elem_data)
   );

   int checks = 0, errors = 0, cyc = 0, req_count = 0;
   int n_got = 0, n_done = 0, done_cyc = 0;
   int last_acc [NB];
   int got_idx [MAXL], got_cyc [MAXL];
   logic [63:0] got_data [MAXL];
   bit finished = 0;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic logic [63:0] mem_word(input logic [31:0] a);
      return {~a, a};
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // behavioural bank array: one-cycle read, busy-time watch for R2
   always @(posedge clk) begin
      rsp_valid <= req_valid;
      rsp_data  <= mem_word({req_row, req_bank});
      if (rst_n && req_valid) begin
         chk(cyc - last_acc[req_bank] >= BUSY, "R2 bank reused while busy",
             cyc - last_acc[req_bank], BUSY);
         last_acc[req_bank] = cyc;
         req_count = req_count + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (elem_valid) begin
            if (n_got < MAXL) begin
               got_idx[n_got]  = int'(elem_idx);
               got_cyc[n_got]  = cyc;
               got_data[n_got] = elem_data;
            end
            n_got = n_got + 1;
         end
         if (done) begin
            n_done   = n_done + 1;
            done_cyc = cyc;
         end
      end
   end

   task automatic run_load(input logic [31:0] b, input logic [31:0] s, input int n,
                           input int inject_at, output int last_rel);
      int exp_t [MAXL];
      int lb [NB];
      int t0, w;
      logic [31:0] a;
      for (int i = 0; i < NB; i++) lb[i] = -100;
      for (int k = 0; k < n; k++) begin
         a = b + 32'(k) * s;
         exp_t[k] = (k == 0) ? 0 : exp_t[k-1] + 1;
         if (lb[a[2:0]] + BUSY > exp_t[k]) exp_t[k] = lb[a[2:0]] + BUSY;
         lb[a[2:0]] = exp_t[k];
      end
      n_got = 0; n_done = 0;
      @(negedge clk);
      start = 1'b1; base = b; stride = s; len = n[6:0];
      @(negedge clk);
      start = 1'b0; t0 = cyc;
      chk(busy == 1'b1, "R8 busy after accepted start", busy, 1);
      w = 0;
      while (n_done == 0 && w < 1000) begin
         if (w == inject_at) begin
            start = 1'b1; base = 32'hDEAD_0000; stride = 32'd5; len = 7'd20;
         end else begin
            start = 1'b0;
         end
         @(negedge clk); #1;
         w++;
      end
      start = 1'b0;
      chk(n_got == n, "R7 element count", n_got, n);
      for (int k = 0; k < n && k < n_got; k++) begin
         a = b + 32'(k) * s;
         chk(got_idx[k] == k, "R7 element order", got_idx[k], k);
         chk(got_data[k] == mem_word(a), "R1 element data", got_data[k], mem_word(a));
         chk(got_cyc[k] - t0 == exp_t[k] + LAT, "R3/R4 element cycle",
             got_cyc[k] - t0, exp_t[k] + LAT);
      end
      chk(done_cyc - t0 == exp_t[n-1] + LAT + 1, "R8 done one cycle after last",
          done_cyc - t0, exp_t[n-1] + LAT + 1);
      chk(busy == 1'b0, "R8 busy low in done cycle", busy, 0);
      last_rel = (n_got > 0) ? got_cyc[(n_got > MAXL ? MAXL : n_got) - 1] - t0 : -1;
   endtask

   task automatic t_reset;
      chk(busy == 0 && done == 0, "R8 reset busy/done", {busy, done}, 0);
      chk(req_valid == 0 && elem_valid == 0, "R8 reset request/element", {req_valid, elem_valid}, 0);
   endtask

   task automatic t_unit_stride;
      int lr;
      run_load(32'h100, 32'd1, 64, -1, lr);
      chk(lr + 1 == 76, "R5 stride-1 load length", lr + 1, 76);
   endtask

   task automatic t_same_bank;
      int lr;
      run_load(32'h40, 32'd32, 64, -1, lr);
      chk(lr + 1 == 391, "R6 stride-32 load length", lr + 1, 391);
      run_load(32'h55, 32'd0, 5, -1, lr);
      chk(lr == 36, "R3 stride-0 serialises", lr, 36);
   endtask

   task automatic t_revisit;
      int lr;
      run_load(32'h0, 32'd2, 16, -1, lr);
      chk(lr == 33, "R11 stride-2 stalls", lr, 33);
      run_load(32'h7, 32'd3, 20, -1, lr);
      chk(lr == 31, "R11 stride-3 streams", lr, 31);
   endtask

   task automatic t_wrap;
      int lr;
      run_load(32'h3, 32'hFFFF_FFFF, 10, -1, lr);
      chk(lr == 21, "R1 downward stride timing", lr, 21);
   endtask

   task automatic t_start_while_busy;
      int lr;
      run_load(32'h200, 32'd1, 8, 3, lr);
      repeat (30) @(negedge clk);
      #1;
      chk(n_done == 1, "R9 single done despite second start", n_done, 1);
      chk(n_got == 8, "R9 no extra elements", n_got, 8);
      chk(busy == 0, "R9 idle after first load", busy, 0);
   endtask

   task automatic t_lengths;
      int rc, lr;
      for (int j = 0; j < 2; j++) begin
         n_got = 0; rc = req_count;
         @(negedge clk);
         start = 1'b1; base = 32'h300; stride = 32'd1; len = (j == 0) ? 7'd0 : 7'd65;
         @(negedge clk);
         start = 1'b0;
         chk(busy == 0, "R10 illegal length busy", busy, 0);
         repeat (15) @(negedge clk);
         chk(req_count == rc && n_got == 0, "R10 illegal length no traffic",
             req_count - rc + n_got, 0);
      end
      run_load(32'h321, 32'd7, 1, -1, lr);
      chk(lr == 12, "R10 single-element load", lr, 12);
   endtask

   initial begin
      for (int i = 0; i < NB; i++) last_acc[i] = -100;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unit_stride();
      t_same_bank();
      t_revisit();
      t_wrap();
      t_start_while_busy();
      t_lengths();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule